// File: doc/BRIEF.md
# Dual-Port Collision Arbiter

This block watches two independent access ports that share one storage array. When both ports are enabled and present the same full-width address, it gives the location to one port and pulls the other port's active-low busy flag low. A port whose busy flag is low has its write qualifier forced inactive, so its write cannot reach the array. Reads are not gated: both ports may read the same word together, and only the flag reports the contention.

Which port wins depends on arrival order. A port is "staying" when it was enabled at the same address on the previous clock. The port that was already at the address keeps it. If both ports arrive together, the left port wins. If both ports are staying, the earlier owner keeps the location.

A strap input selects the mode. In master mode the block drives its own busy flags. In slave mode the internal comparator is ignored and the busy outputs are held high. The write qualifiers then follow busy flags supplied by an external master. Several devices can therefore share one decision when they are ganged for a wider word. The design is a synchronous clocked model. Its asynchronous active-low reset is released synchronously.

Top module: `dp_collision_arb`

## Requirements
- R1: While reset is held, and after its release, two ports that have stayed enabled at one address since reset are treated as arriving together. The left port holds the location: right busy is 0 and left busy is 1. When no address matches, both busy flags are 1.
- R2: In master mode a busy flag goes low only when both enables are 1 and all AW address bits are equal. Any differing bit, including the most significant bit, leaves both flags at 1.
- R3: When both ports arrive at a matching address in the same cycle (neither was staying), the right busy flag is 0 and the left flag is 1.
- R4: When one port was staying at the address and the other arrives, the arriving port's busy flag is 0. While both keep staying, the previous winner keeps the location.
- R5: Busy is released in the same cycle that the addresses stop matching or the other port's enable drops.
- R6: In master mode at most one of the two busy outputs is 0 in any cycle.
- R7: A port's write qualifier is 1 exactly when its enable and write inputs are 1 and its effective busy flag is 1. A port whose busy flag is 0 therefore gets qualifier 0.
- R8: In slave mode (master_sel=0) both busy outputs are 1 whatever the addresses are. The effective busy flag of each port is the matching external input (lft_busy_in_n, rgt_busy_in_n).
- R9: After a collision ends, the next collision is decided afresh by R3 and R4, with no memory of the earlier winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_sel | input | 1 | 1 = master (drive busy), 0 = slave (take busy from inputs) |
| lft_en | input | 1 | Left port enable, active high |
| lft_wr | input | 1 | Left port write request |
| lft_addr | input | AW | Left port address |
| rgt_en | input | 1 | Right port enable, active high |
| rgt_wr | input | 1 | Right port write request |
| rgt_addr | input | AW | Right port address |
| lft_busy_in_n | input | 1 | External left busy flag, used in slave mode |
| rgt_busy_in_n | input | 1 | External right busy flag, used in slave mode |
| lft_busy_out_n | output | 1 | Left busy flag, active low |
| rgt_busy_out_n | output | 1 | Right busy flag, active low |
| lft_wr_ok | output | 1 | Left write qualifier |
| rgt_wr_ok | output | 1 | Right write qualifier |

## Verification
The only state is the per-port record of the previous enable and address, plus the latched winner. A wrong record shows up at the ports in the very cycle after it was captured: the arriving port is misjudged as staying (or the reverse), and the busy flag lands on the wrong side. A stale winner only matters while both ports keep staying. It therefore shows up within one cycle of a held collision as a busy flag that flips sides. The sweeps cover every address pair of a 4-bit configuration, both arrival orders and held contention, so any such fault reaches a compared output within one to three cycles of its cause.

// File: rtl/coll_arb_pkg.sv
package coll_arb_pkg;
  localparam int NUM_PORTS = 2;
  localparam int PORT_L    = 0;
  localparam int PORT_R    = 1;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } own_e;
endpackage

// File: rtl/coll_arb_rstsync.sv
module coll_arb_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/coll_arb_track.sv
module coll_arb_track #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [AW-1:0] addr_i,
  output logic          stay_o
);
  logic          prev_en_q, prev_en_d;
  logic [AW-1:0] prev_addr_q, prev_addr_d;
  logic          addr_ce;

  // Address register loads only while the port is enabled.
  always_comb begin
    prev_en_d   = en_i;
    addr_ce     = en_i;
    prev_addr_d = addr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_en_q   <= 1'b0;
      prev_addr_q <= '0;
    end else begin
      prev_en_q <= prev_en_d;
      if (addr_ce) prev_addr_q <= prev_addr_d;
    end
  end

  assign stay_o = en_i & prev_en_q & (addr_i == prev_addr_q);

  AST_STAY_NEEDS_HISTORY: assert property (@(posedge clk) disable iff (!rst_n)
    stay_o |-> ($past(en_i) && addr_i == $past(addr_i))) else $error("stay"); // R4
endmodule

// File: rtl/coll_arb_grant.sv
module coll_arb_grant
  import coll_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic match_i,
  input  logic stay_l_i,
  input  logic stay_r_i,
  output own_e win_o
);
  own_e owner_q;
  own_e win_d;
  logic own_ce;

  always_comb begin
    if (!active_i || !match_i)      win_d = OWN_NONE;
    else if (stay_l_i && !stay_r_i) win_d = OWN_LEFT;
    else if (stay_r_i && !stay_l_i) win_d = OWN_RIGHT;
    else if (stay_l_i && stay_r_i && owner_q != OWN_NONE) win_d = owner_q;
    else                            win_d = OWN_LEFT;
    own_ce = (win_d != owner_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      owner_q <= OWN_NONE;
    else if (own_ce) owner_q <= win_d;
  end

  assign win_o = win_d;

  AST_HOLD_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && match_i && stay_l_i && stay_r_i && $past(win_o) != OWN_NONE)
      |-> (win_o == $past(win_o))) else $error("hold"); // R4
  AST_IDLE_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!match_i) |-> (win_o == OWN_NONE)) else $error("idle"); // R5
endmodule

// File: rtl/dp_collision_arb.sv
module dp_collision_arb
  import coll_arb_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master_sel,
  input  logic          lft_en,
  input  logic          lft_wr,
  input  logic [AW-1:0] lft_addr,
  input  logic          rgt_en,
  input  logic          rgt_wr,
  input  logic [AW-1:0] rgt_addr,
  input  logic          lft_busy_in_n,
  input  logic          rgt_busy_in_n,
  output logic          lft_busy_out_n,
  output logic          rgt_busy_out_n,
  output logic          lft_wr_ok,
  output logic          rgt_wr_ok
);
  logic                           rst_ns;
  logic [NUM_PORTS-1:0]           en_v;
  logic [NUM_PORTS-1:0][AW-1:0]   addr_v;
  logic [NUM_PORTS-1:0]           stay_v;
  logic                           match;
  own_e                           win;
  logic                           busy_int_l_n, busy_int_r_n;
  logic                           busy_eff_l_n, busy_eff_r_n;

  coll_arb_rstsync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_ns)
  );

  assign en_v[PORT_L]   = lft_en;
  assign en_v[PORT_R]   = rgt_en;
  assign addr_v[PORT_L] = lft_addr;
  assign addr_v[PORT_R] = rgt_addr;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_trk
    coll_arb_track #(.AW(AW)) u_trk (
      .clk    (clk),
      .rst_n  (rst_ns),
      .en_i   (en_v[g]),
      .addr_i (addr_v[g]),
      .stay_o (stay_v[g])
    );
  end

  assign match = lft_en & rgt_en & (lft_addr == rgt_addr);

  coll_arb_grant u_grant (
    .clk      (clk),
    .rst_n    (rst_ns),
    .active_i (master_sel),
    .match_i  (match),
    .stay_l_i (stay_v[PORT_L]),
    .stay_r_i (stay_v[PORT_R]),
    .win_o    (win)
  );

  always_comb begin
    busy_int_l_n   = (win != OWN_RIGHT);
    busy_int_r_n   = (win != OWN_LEFT);
    busy_eff_l_n   = master_sel ? busy_int_l_n : lft_busy_in_n;
    busy_eff_r_n   = master_sel ? busy_int_r_n : rgt_busy_in_n;
    lft_busy_out_n = master_sel ? busy_int_l_n : 1'b1;
    rgt_busy_out_n = master_sel ? busy_int_r_n : 1'b1;
    lft_wr_ok      = lft_en & lft_wr & busy_eff_l_n;
    rgt_wr_ok      = rgt_en & rgt_wr & busy_eff_r_n;
  end

  AST_ONE_BUSY: assert property (@(posedge clk) disable iff (!rst_ns)
    master_sel |-> (lft_busy_out_n || rgt_busy_out_n)) else $error("two busy"); // R6
  AST_BUSY_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_ns)
    (!lft_busy_out_n || !rgt_busy_out_n) |-> (lft_en && rgt_en && lft_addr == rgt_addr))
    else $error("busy w/o match"); // R2
  AST_WR_BLOCK_L: assert property (@(posedge clk) disable iff (!rst_ns)
    (master_sel && !lft_busy_out_n) |-> !lft_wr_ok) else $error("left wr"); // R7
  AST_WR_BLOCK_R: assert property (@(posedge clk) disable iff (!rst_ns)
    (master_sel && !rgt_busy_out_n) |-> !rgt_wr_ok) else $error("right wr"); // R7
  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_ns)
    !master_sel |-> (lft_busy_out_n && rgt_busy_out_n)) else $error("slave drive"); // R8
  AST_SLAVE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_ns)
    (!master_sel && (!lft_busy_in_n || !rgt_busy_in_n))
      |-> !((lft_wr_ok && !lft_busy_in_n) || (rgt_wr_ok && !rgt_busy_in_n)))
    else $error("slave follow"); // R8
endmodule

// File: tb/dp_collision_arb_tb.sv
module dp_collision_arb_tb;
  localparam int AW = 4;
  localparam int NA = 1 << AW;

  logic clk = 1'b0;
  logic rst_n;
  logic master_sel;
  logic lft_en, lft_wr, rgt_en, rgt_wr;
  logic [AW-1:0] lft_addr, rgt_addr;
  logic lft_busy_in_n, rgt_busy_in_n;
  logic lft_busy_out_n, rgt_busy_out_n, lft_wr_ok, rgt_wr_ok;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  dp_collision_arb #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .master_sel(master_sel),
    .lft_en(lft_en), .lft_wr(lft_wr), .lft_addr(lft_addr),
    .rgt_en(rgt_en), .rgt_wr(rgt_wr), .rgt_addr(rgt_addr),
    .lft_busy_in_n(lft_busy_in_n), .rgt_busy_in_n(rgt_busy_in_n),
    .lft_busy_out_n(lft_busy_out_n), .rgt_busy_out_n(rgt_busy_out_n),
    .lft_wr_ok(lft_wr_ok), .rgt_wr_ok(rgt_wr_ok)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Outputs packed as {lft_busy_out_n, rgt_busy_out_n, lft_wr_ok, rgt_wr_ok}
  function automatic logic [3:0] outs();
    return {lft_busy_out_n, rgt_busy_out_n, lft_wr_ok, rgt_wr_ok};
  endfunction

  task automatic drive(input logic le, input logic [AW-1:0] la, input logic lw,
                       input logic re, input logic [AW-1:0] ra, input logic rw);
    @(negedge clk);
    lft_en = le; lft_addr = la; lft_wr = lw;
    rgt_en = re; rgt_addr = ra; rgt_wr = rw;
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; master_sel = 1'b1;
    lft_busy_in_n = 1'b1; rgt_busy_in_n = 1'b1;
    lft_en = 0; rgt_en = 0; lft_wr = 0; rgt_wr = 0; lft_addr = '0; rgt_addr = '0;
    #1;
    chk("R1 idle in reset", outs(), 4'b1100);
    // R1: both present from reset at address 5, writing
    drive(1, 4'd5, 1, 1, 4'd5, 1);
    chk("R1 shared from reset", outs(), 4'b1010);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) begin
      drive(1, 4'd5, 1, 1, 4'd5, 1);
      chk("R1 after release", outs(), 4'b1010);
    end
    drive(0, 4'd0, 0, 0, 4'd0, 0);
    chk("R1 idle", outs(), 4'b1100);

    // R2 R3 R7: simultaneous arrival sweep
    for (int le = 0; le < 2; le++)
      for (int re = 0; re < 2; re++)
        for (int a = 0; a < NA; a++)
          for (int b = 0; b < NA; b++) begin
            logic coll;
            drive(0, '0, 0, 0, '0, 0);
            drive(le[0], a[AW-1:0], 1, re[0], b[AW-1:0], 1);
            coll = le[0] && re[0] && (a == b);
            chk(coll ? "R3 simultaneous left wins" : "R2 no collision",
                outs(), {1'b1, !coll, le[0], re[0] && !coll});
          end

    // R4 R5 R9: right first then left joins; then held; then release
    for (int a = 0; a < NA; a++)
      for (int b = 0; b < NA; b++) begin
        logic coll;
        drive(0, '0, 0, 0, '0, 0);
        drive(0, '0, 0, 1, a[AW-1:0], 1);
        chk("R7 lone right writes", outs(), 4'b1101);
        drive(1, b[AW-1:0], 1, 1, a[AW-1:0], 1);
        coll = (a == b);
        chk("R4 right keeps", outs(), {!coll, 1'b1, !coll, 1'b1});
        drive(1, b[AW-1:0], 1, 1, a[AW-1:0], 1);
        chk("R4 held", outs(), {!coll, 1'b1, !coll, 1'b1});
        drive(1, b[AW-1:0], 1, 0, a[AW-1:0], 1);
        chk("R5 release by deselect", outs(), 4'b1110);
      end

    // R4 R5: left first then right joins; release by address change
    for (int a = 0; a < NA; a++) begin
      drive(0, '0, 0, 0, '0, 0);
      drive(1, a[AW-1:0], 1, 0, '0, 0);
      drive(1, a[AW-1:0], 1, 1, a[AW-1:0], 1);
      chk("R4 left keeps", outs(), 4'b1010);
      drive(1, a[AW-1:0], 1, 1, a[AW-1:0] ^ 4'd8, 1);
      chk("R5 release by mismatch msb", outs(), 4'b1111);
    end

    // R9: right owned, collision ends, both leave and return together -> left
    drive(0, '0, 0, 0, '0, 0);
    drive(0, '0, 0, 1, 4'd3, 0);
    drive(1, 4'd3, 0, 1, 4'd3, 0);
    chk("R4 read collision flags left", outs(), 4'b0100);
    drive(0, '0, 0, 0, '0, 0);
    drive(1, 4'd3, 1, 1, 4'd3, 1);
    chk("R9 fresh decision", outs(), 4'b1010);
    drive(1, 4'd3, 1, 1, 4'd3, 1);
    chk("R6 one busy held", outs(), 4'b1010);

    // R8: slave mode, comparator ignored, qualifiers follow external flags
    drive(0, '0, 0, 0, '0, 0);
    master_sel = 1'b0;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      lft_busy_in_n = k[0]; rgt_busy_in_n = k[1];
      lft_wr = k[2]; rgt_wr = k[3]; lft_en = k[4]; rgt_en = k[5];
      lft_addr = 4'd9; rgt_addr = 4'd9;
      #1;
      chk("R8 slave", outs(), {2'b11, k[4] & k[2] & k[0], k[5] & k[3] & k[1]});
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule